// File: doc/BRIEF.md
# One-Time Fuse Word Controller

This block sits between a simple register bus and an array of one-time-programmable fuses. The array is organised as 32-bit words. Software reaches the array through three registers: a control register, a program-data register and a read-data register. To program a word, software first loads the program-data register. It then writes the control register with three things at once: a word index, an unlock byte equal to the fixed lock constant, and the program start bit. To read a word, software writes the index, the unlock byte and the read start bit.

While an operation runs, the controller holds the fuse address and data steady and drives either a program strobe or a sense strobe for a fixed number of cycles. The start bit that launched the operation reads back as 1 for that whole time. When the operation finishes, the start bit clears by itself, so software polls it to learn when the operation is done. A read places the sensed word in the read-data register. Programming can only turn fuse bits from 0 to 1, so a programmed word becomes the old contents OR the new data.

The bus and the fuse-side signals are plain, single-cycle control signals. No payload streams through the block, so there is no valid/ready handshake. A bus write takes effect on the clock edge where `bus_wr` is high, and `bus_rdata` is a combinational view of the register selected by `bus_addr`.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the control, program-data and read-data registers all read 0, and both fuse strobes are low.
- R2: The register addresses are 0 for control, 1 for program data, 2 for read data; address 3 reads 0. In the control register, bits [24:16] hold the 9-bit word index, bits [15:8] hold the unlock byte, bit 0 is the program start bit and bit 1 is the read start bit. An idle write stores the index and the unlock byte, and they read back unchanged.
- R3: A control write made while idle starts a program operation when its unlock byte equals LOCK_KEY (default 8'hA5) and bits [1:0] are 2'b01. The operation proceeds as follows:
  - `fuse_prog` is high for exactly PROG_CYCLES cycles, starting the cycle after the write.
  - During that time `fuse_addr` equals the index and `fuse_wdata` equals the program-data register.
  - Control bit 0 reads 1 for that whole time and clears when the strobe ends.
- R4: After a program operation, the addressed word reads back as its previous value OR the program data.
- R5: A control write made while idle starts a read operation when its unlock byte equals LOCK_KEY and bits [1:0] are 2'b10. The operation proceeds as follows:
  - `fuse_sense` is high for exactly READ_CYCLES cycles.
  - Control bit 1 reads 1 for that whole time.
  - In the cycle the bit clears, the read-data register holds `fuse_rdata` as it was in the last sense cycle.
- R6: A control write whose unlock byte differs from LOCK_KEY starts nothing. No strobe rises, and both start bits read 0 in the next cycle.
- R7: A control write with both start bits set starts nothing, even when the unlock byte matches. Both start bits read 0 in the next cycle.
- R8: Control writes made while an operation runs are ignored. The index, the unlock byte and the running operation are all left unchanged.
- R9: Program-data writes made while an operation runs are ignored.
- R10: The read-data register changes only when a read operation completes. Bus writes to address 2 and program operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select (0 control, 1 program data, 2 read data) |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the selected register |
| fuse_addr | output | 9 | Word index presented to the fuse array |
| fuse_wdata | output | 32 | Bits to blow during a program operation |
| fuse_prog | output | 1 | Program strobe, held for PROG_CYCLES cycles |
| fuse_sense | output | 1 | Sense strobe, held for READ_CYCLES cycles |
| fuse_rdata | input | 32 | Word returned by the array for `fuse_addr` |

## Verification
The hardest case to reach from the ports is a bus write that arrives while an operation is already running. The stimulus therefore issues a program start and then, in the very next cycles, a second control write that carries a valid unlock byte and the read bit, followed by a program-data write. A reference model runs cycle by cycle and follows the strobes, so an early end, a late end or a second operation starting shows up in the exact cycle where it happens. Refused starts (a wrong unlock byte, or both start bits set) are checked by reading the start bits back one cycle later, and by confirming that no strobe rises. The top index, 511, is exercised for both a program operation and a read operation.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam logic [1:0] ADDR_CTL   = 2'd0;
  localparam logic [1:0] ADDR_PDATA = 2'd1;
  localparam logic [1:0] ADDR_RDATA = 2'd2;
  localparam int         KEY_LSB    = 8;
  localparam int         IDX_LSB    = 16;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_SENSE = 2'd2
  } op_e;
endpackage

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
  import fuse_ctl_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          IDX_W    = 9,
  parameter logic [7:0]  LOCK_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  op_e               cur_op,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] pdata,
  output logic              go_prog,
  output logic              go_sense
);
  logic              idle;
  logic              ctl_wr;
  logic              pd_wr;
  logic              key_ok;
  logic [7:0]        key_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] pdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] ctl_view;

  assign idle     = (cur_op == OP_IDLE);
  assign ctl_wr   = bus_wr && (bus_addr == ADDR_CTL) && idle;
  assign pd_wr    = bus_wr && (bus_addr == ADDR_PDATA) && idle;
  assign key_ok   = (bus_wdata[KEY_LSB +: 8] == LOCK_KEY);
  assign go_prog  = ctl_wr && key_ok && (bus_wdata[1:0] == 2'b01);
  assign go_sense = ctl_wr && key_ok && (bus_wdata[1:0] == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      key_q   <= '0;
      pdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (ctl_wr) begin
        idx_q <= bus_wdata[IDX_LSB +: IDX_W];
        key_q <= bus_wdata[KEY_LSB +: 8];
      end
      if (pd_wr) pdata_q <= bus_wdata;
      if (cap_en) rdata_q <= cap_data;
    end
  end

  always_comb begin
    ctl_view                   = '0;
    ctl_view[IDX_LSB +: IDX_W] = idx_q;
    ctl_view[KEY_LSB +: 8]     = key_q;
    ctl_view[1]                = (cur_op == OP_SENSE);
    ctl_view[0]                = (cur_op == OP_PROG);
    case (bus_addr)
      ADDR_CTL:   bus_rdata = ctl_view;
      ADDR_PDATA: bus_rdata = pdata_q;
      ADDR_RDATA: bus_rdata = rdata_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign idx   = idx_q;
  assign pdata = pdata_q;

  AST_BUSY_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CTL && !idle) |=> ($stable(idx_q) && $stable(key_q))); // R8
  AST_BUSY_PDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_PDATA && !idle) |=> $stable(pdata_q)); // R9
  AST_RDATA_ONLY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rdata_q)); // R10
endmodule

// File: rtl/fuse_ctl_seq.sv
module fuse_ctl_seq
  import fuse_ctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 9,
  parameter int PROG_CYCLES = 20,
  parameter int READ_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_prog,
  input  logic              go_sense,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] pdata,
  output op_e               cur_op,
  output logic              cap_en,
  output logic [IDX_W-1:0]  fuse_addr,
  output logic [DATA_W-1:0] fuse_wdata,
  output logic              fuse_prog,
  output logic              fuse_sense
);
  localparam int MAXC = (PROG_CYCLES > READ_CYCLES) ? PROG_CYCLES : READ_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] READ_LAST = CW'(READ_CYCLES - 1);

  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = ((op_q == OP_PROG) && (cnt_q == PROG_LAST)) ||
                ((op_q == OP_SENSE) && (cnt_q == READ_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (op_q == OP_IDLE) begin
      cnt_q <= '0;
      if (go_prog)       op_q <= OP_PROG;
      else if (go_sense) op_q <= OP_SENSE;
    end else if (last) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cur_op     = op_q;
  assign cap_en     = (op_q == OP_SENSE) && last;
  assign fuse_addr  = idx;
  assign fuse_wdata = pdata;
  assign fuse_prog  = (op_q == OP_PROG);
  assign fuse_sense = (op_q == OP_SENSE);

  AST_NO_START_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_IDLE && !go_prog && !go_sense) |=> (op_q == OP_IDLE)); // R6
  AST_SINGLE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_prog && go_sense)); // R7
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_ctl_pkg::*;
#(
  parameter int         DATA_W      = 32,
  parameter int         IDX_W       = 9,
  parameter logic [7:0] LOCK_KEY    = 8'hA5,
  parameter int         PROG_CYCLES = 20,
  parameter int         READ_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  fuse_addr,
  output logic [DATA_W-1:0] fuse_wdata,
  output logic              fuse_prog,
  output logic              fuse_sense,
  input  logic [DATA_W-1:0] fuse_rdata
);
  op_e               cur_op;
  logic              cap_en;
  logic              go_prog;
  logic              go_sense;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] pdata;

  fuse_ctl_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .LOCK_KEY(LOCK_KEY)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_op(cur_op), .cap_en(cap_en), .cap_data(fuse_rdata),
    .idx(idx), .pdata(pdata), .go_prog(go_prog), .go_sense(go_sense)
  );

  fuse_ctl_seq #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES), .READ_CYCLES(READ_CYCLES)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .go_prog(go_prog), .go_sense(go_sense), .idx(idx), .pdata(pdata),
    .cur_op(cur_op), .cap_en(cap_en),
    .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata),
    .fuse_prog(fuse_prog), .fuse_sense(fuse_sense)
  );

  AST_PROG_OPERANDS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_prog && $past(fuse_prog)) |-> ($stable(fuse_wdata) && $stable(fuse_addr))); // R3
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fuse_prog, fuse_sense, go_prog && fuse_prog})); // R5
endmodule

// File: tb/fuse_ctl_tb_top.sv
module fuse_ctl_tb_top;
  localparam int         PROG_N = 12;
  localparam int         READ_N = 3;
  localparam logic [7:0] KEY    = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  fuse_addr;
  logic [31:0] fuse_wdata;
  logic        fuse_prog;
  logic        fuse_sense;
  logic [31:0] fuse_rdata;

  logic [31:0] mem [0:511];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // behavioural reference state
  int          m_state;
  int          m_left;
  logic        m_idle;
  logic [8:0]  m_idx;
  logic [7:0]  m_key;
  logic [31:0] m_pd;
  logic [31:0] m_rd;

  always #5 clk = ~clk;

  fuse_ctl #(.LOCK_KEY(KEY), .PROG_CYCLES(PROG_N), .READ_CYCLES(READ_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
    .fuse_wdata(fuse_wdata), .fuse_prog(fuse_prog), .fuse_sense(fuse_sense),
    .fuse_rdata(fuse_rdata)
  );

  assign fuse_rdata = mem[fuse_addr];

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = (i * 32'h0101_0101) ^ 32'h0F00_0000;
  end

  always @(negedge clk) if (fuse_prog) mem[fuse_addr] <= mem[fuse_addr] | fuse_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_left = 0; m_idx = '0; m_key = '0; m_pd = '0; m_rd = '0;
    end else begin
      m_idle = (m_state == 0);
      if (!m_idle) begin
        if (m_state == 2 && m_left == 1) m_rd = mem[m_idx];
        m_left--;
        if (m_left == 0) m_state = 0;
      end
      if (bus_wr && m_idle) begin
        if (bus_addr == 2'd0) begin
          m_idx = bus_wdata[24:16];
          m_key = bus_wdata[15:8];
          if (m_key == KEY && bus_wdata[1:0] == 2'b01) begin m_state = 1; m_left = PROG_N; end
          else if (m_key == KEY && bus_wdata[1:0] == 2'b10) begin m_state = 2; m_left = READ_N; end
        end else if (bus_addr == 2'd1) begin
          m_pd = bus_wdata;
        end
      end
    end
  end

  // per-clock comparison of the fuse-side strobes against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 prog strobe", {31'b0, fuse_prog}, {31'b0, m_state == 1});
      chk("R5 sense strobe", {31'b0, fuse_sense}, {31'b0, m_state == 2});
      if (m_state != 0) chk("R3 fuse_addr", {23'b0, fuse_addr}, {23'b0, m_idx});
      if (m_state == 1) chk("R3 fuse_wdata", fuse_wdata, m_pd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] model_view(input logic [1:0] a);
    case (a)
      2'd0: return {7'b0, m_idx, m_key, 6'b0, m_state == 2, m_state == 1};
      2'd1: return m_pd;
      2'd2: return m_rd;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
    chk(tag, v, model_view(a));
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      rd(tag, 2'd0, v);
      if (v[1:0] == 2'b00) break;
    end
  endtask

  function automatic logic [31:0] ctl(input logic [8:0] i, input logic [7:0] k, input logic [1:0] s);
    return {7'b0, i, k, 6'b0, s};
  endfunction

  initial begin
    logic [31:0] v;
    logic [31:0] old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    bus_addr = 2'd0; #1; chk("R1 ctl reset", bus_rdata, 32'h0);
    bus_addr = 2'd1; #1; chk("R1 pdata reset", bus_rdata, 32'h0);
    bus_addr = 2'd2; #1; chk("R1 rdata reset", bus_rdata, 32'h0);
    chk("R1 strobes", {30'b0, fuse_prog, fuse_sense}, 32'h0);

    // R2: field layout readback without starting
    wr(2'd0, ctl(9'd5, 8'h3C, 2'b00));
    rd("R2 ctl fields", 2'd0, v);
    chk("R2 ctl fields explicit", v, 32'h0005_3C00);
    bus_addr = 2'd3; #1; chk("R2 addr3 zero", bus_rdata, 32'h0);

    // R3/R8/R9: program word 5 and disturb it while busy
    old = mem[5];
    wr(2'd1, 32'h0000_00F0);
    wr(2'd0, ctl(9'd5, KEY, 2'b01));
    rd("R3 busy bit", 2'd0, v);
    chk("R3 bit0 set while programming", {31'b0, v[0]}, 32'd1);
    wr(2'd0, ctl(9'd9, KEY, 2'b10));
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R8 ctl during busy", 2'd0, v);
    chk("R8 index kept", {23'b0, v[24:16]}, 32'd5);
    rd("R9 pdata during busy", 2'd1, v);
    chk("R9 pdata kept", v, 32'h0000_00F0);
    wait_idle("R3 poll");
    rd("R10 rdata after program", 2'd2, v);
    chk("R10 rdata untouched by program", v, 32'h0);

    // R4/R5: read back word 5
    wr(2'd0, ctl(9'd5, KEY, 2'b10));
    rd("R5 busy bit", 2'd0, v);
    chk("R5 bit1 set while sensing", {30'b0, v[1:0]}, 32'd2);
    wait_idle("R5 poll");
    rd("R5 rdata", 2'd2, v);
    chk("R4 old OR data", v, old | 32'h0000_00F0);

    // R6: wrong key
    wr(2'd0, ctl(9'd7, 8'h5A, 2'b10));
    rd("R6 ctl", 2'd0, v);
    chk("R6 start bits cleared", {30'b0, v[1:0]}, 32'd0);
    repeat (4) begin
      @(negedge clk);
      chk("R6 no strobe", {30'b0, fuse_prog, fuse_sense}, 32'h0);
    end

    // R7: both start bits
    wr(2'd0, ctl(9'd7, KEY, 2'b11));
    rd("R7 ctl", 2'd0, v);
    chk("R7 start bits cleared", {30'b0, v[1:0]}, 32'd0);
    repeat (4) begin
      @(negedge clk);
      chk("R7 no strobe", {30'b0, fuse_prog, fuse_sense}, 32'h0);
    end

    // R10: bus write to read-data address has no effect
    wr(2'd2, 32'hDEAD_BEEF);
    rd("R10 rdata write ignored", 2'd2, v);
    chk("R10 rdata explicit", v, old | 32'h0000_00F0);

    // top index: program then read word 511
    old = mem[511];
    wr(2'd1, 32'h8000_0001);
    wr(2'd0, ctl(9'd511, KEY, 2'b01));
    wait_idle("R3 poll 511");
    wr(2'd0, ctl(9'd511, KEY, 2'b10));
    wait_idle("R5 poll 511");
    rd("R5 rdata 511", 2'd2, v);
    chk("R4 word 511", v, old | 32'h8000_0001);

    repeat (3) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule